// File: doc/BRIEF.md
# Quad-SPI Indirect Command Sequencer

This block runs one serial-flash command at a time over a four-lane SPI bus. Software places a command word, a 24-bit address, a byte count and a clock divider on its inputs. It then pulses a start strobe. The sequencer drops chip-select and clocks out up to four phases, in a fixed order:

1. an instruction byte, on one lane or on four lanes;
2. an optional 24-bit address, on four lanes;
3. an optional gap of dummy clocks, with all lanes released;
4. an optional data phase, on four lanes.

Each phase is switched on or off by its own field of the command word. Bytes to be written are taken from a small transmit FIFO. Bytes that are read are put into a small receive FIFO.

The serial clock idles low, and the flash samples on the rising edge (SPI mode 0). The sequencer changes its outputs only at falling edges. The bus clock is paused at the start of a clock, with the clock line held low, in two cases: the transmit FIFO has run dry during a write, or the receive FIFO is full during a read. The transfer therefore never loses or invents a byte. A busy flag covers the whole command, including a chip-select-high guard time after it. A sticky done flag marks the end of the command.

Top module: `qspi_cmd_seq`

## Requirements
- R1: After reset, `csN` is 1, `sck` is 0, `busy` is 0 and `doneFlag` is 0. `ioOe` is 0, `rxEmpty` is 1 and `txFull` is 0.
- R2: While chip-select is low, one bus clock lasts `clkDiv`+1 system cycles, and a `clkDiv` of 0 is treated as 1. The clock is high for floor((`clkDiv`+1)/2) cycles and low for the rest. `sck` is 0 whenever `csN` is 1.
- R3: Command bits [7:0] hold the instruction byte and bits [9:8] select its lane mode. Code 00 skips the phase. Code 01 sends the byte on `ioOut[0]` only, MSB first, over 8 clocks, with `ioOe`=0001. Codes 10 and 11 send it on four lanes, high nibble first, over 2 clocks, with `ioOe`=1111.
- R4: A nonzero value in bits [11:10] adds a 24-bit address phase after the instruction. The address comes from `cmdAddr` and goes out over 6 clocks on four lanes, most significant nibble first. A value of 00 skips the address phase.
- R5: Bits [22:18] give the number of dummy clocks that follow the address. During these clocks `ioOe` is 0. A count of 0 skips the dummy phase.
- R6: A nonzero value in bits [25:24] enables a data phase of `xferLen`+1 bytes, so an `xferLen` of 0 moves exactly one byte. Each byte takes two clocks.
- R7: Bits [27:26] equal to 01 make the command a read. During the data phase of a read, `ioOe` is 0. `ioIn` is sampled at the falling edge that ends each clock, and the high nibble of each byte comes first. Bytes enter the receive FIFO in bus order, and `rxData` shows the oldest byte.
- R8: Any other value in bits [27:26] makes the command a write. The write data goes out on four lanes, high nibble first, taken from the transmit FIFO in the order the bytes were pushed. A write with bits [25:24] at 00 ends after its instruction and address and has no data phase.
- R9: During a write data phase, when the next byte is needed and the transmit FIFO is empty, `sck` stays low. The transfer resumes after a byte is pushed.
- R10: During a read data phase, while the receive FIFO is full, `sck` stays low. No byte is lost or overwritten.
- R11: A start pulse is accepted only while `busy` is 0, and pulses seen while `busy` is 1 are ignored. `busy` stays 1 from acceptance until chip-select has been high for one full bus clock.
- R12: `doneFlag` is set when chip-select rises at the end of a command. It stays set until `doneClr` is pulsed.
- R13: `ioOut` never changes while `sck` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | Start pulse; the command fields are taken in this cycle |
| cmdWord | input | 32 | Command word (instruction, lane modes, dummy count, direction) |
| cmdAddr | input | 24 | Flash address for the address phase |
| xferLen | input | LEN_W | Data byte count minus one |
| clkDiv | input | PRE_W | Bus clock divider; period is `clkDiv`+1 system cycles |
| txData | input | 8 | Byte to push into the transmit FIFO |
| txPush | input | 1 | Push strobe for the transmit FIFO |
| txFull | output | 1 | Transmit FIFO full |
| rxData | output | 8 | Oldest byte in the receive FIFO |
| rxPop | input | 1 | Pop strobe for the receive FIFO |
| rxEmpty | output | 1 | Receive FIFO empty |
| doneClr | input | 1 | Clears the done flag |
| doneFlag | output | 1 | Sticky end-of-command flag |
| busy | output | 1 | Command in progress, including the chip-select guard time |
| csN | output | 1 | Flash chip-select, active low |
| sck | output | 1 | Bus clock |
| ioOut | output | 4 | Lane output values |
| ioOe | output | 4 | Lane output enables |
| ioIn | input | 4 | Lane input values |

## Verification
The bench attaches a small flash model to the bus. The model presents a new nibble after every falling edge once the read data phase has begun, and it records each lane value and enable at every rising edge. The corner cases it targets are these:

- A one-lane instruction. A design that shifted four bits per clock would finish in 2 clocks instead of 8.
- A write whose transmit FIFO starts empty, and a six-byte read into a four-entry receive FIFO. A design without the pause would clock out stale bytes, or drop the fifth and sixth bytes.
- A byte count of zero. An off-by-one design would move two bytes instead of one.
- A start pulse sent in the middle of a command. A design that accepted it would run a second command straight after the first.
- Divider values of 0, 3 and 4, including an odd bus period. A mistake in the split between high and low time shows up as a wrong period or a wrong high-time count.

// File: rtl/qspi_seq_pkg.sv
package qspi_seq_pkg;

  // Command-word field positions, decoded by the sequencer.
  localparam int INSTR_LSB = 0;
  localparam int IMODE_LSB = 8;
  localparam int AMODE_LSB = 10;
  localparam int DCYC_LSB  = 18;
  localparam int DMODE_LSB = 24;
  localparam int FMODE_LSB = 26;
  localparam logic [1:0] FMODE_READ = 2'b01;

  // The numeric order of the phases is the order they appear on the bus.
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_INSTR = 3'd1,
    PH_ADDR  = 3'd2,
    PH_DUMMY = 3'd3,
    PH_DATA  = 3'd4,
    PH_GUARD = 3'd5
  } phase_t;

  typedef enum logic [1:0] {DRV_OFF, DRV_ONE, DRV_QUAD} drive_t;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic   accept;
    logic   loadInstr;
    logic   loadAddr;
    logic   loadTx;
    logic   shift1;
    logic   shift4;
    logic   sampleIn;
    logic   pushRx;
    drive_t drive;
  } dp_ctl_t;

endpackage

// File: rtl/qspi_fifo.sv
module qspi_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] headData,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign headData = mem[rdPtr];

  wire doPush = push && !full;
  wire doPop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) begin
        mem[wrPtr] <= pushData;
        wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      end
      if (doPop) rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop) count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/qspi_dp.sv
module qspi_dp
  import qspi_seq_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  dp_ctl_t       ctl,
  input  logic          sckIn,
  input  logic [7:0]    cmdInstr,
  input  logic [23:0]   cmdAddr,
  input  logic [7:0]    txData,
  input  logic          txPush,
  input  logic          rxPop,
  input  logic [3:0]    ioIn,
  output logic [3:0]    ioOut,
  output logic [3:0]    ioOe,
  output logic          txFull,
  output logic          txEmpty,
  output logic [7:0]    rxData,
  output logic          rxEmpty,
  output logic          rxFull
);
  logic [31:0] shiftReg;
  logic [23:0] addrReg;
  logic [3:0]  rxNib;
  logic [7:0]  txHead;

  qspi_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN), .push(txPush), .pushData(txData),
    .pop(ctl.loadTx), .headData(txHead), .full(txFull), .empty(txEmpty)
  );

  qspi_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN), .push(ctl.pushRx), .pushData({rxNib, ioIn}),
    .pop(rxPop), .headData(rxData), .full(rxFull), .empty(rxEmpty)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      addrReg  <= '0;
      rxNib    <= '0;
    end else begin
      if (ctl.accept) addrReg <= cmdAddr;
      if (ctl.loadInstr)   shiftReg <= {cmdInstr, 24'h0};
      else if (ctl.loadAddr) shiftReg <= {(ctl.accept ? cmdAddr : addrReg), 8'h0};
      else if (ctl.loadTx) shiftReg <= {txHead, 24'h0};
      else if (ctl.shift1) shiftReg <= {shiftReg[30:0], 1'b0};
      else if (ctl.shift4) shiftReg <= {shiftReg[27:0], 4'h0};
      if (ctl.sampleIn) rxNib <= ioIn;
    end
  end

  // One lane per bit; lane 0 also carries single-line traffic.
  for (genvar lane = 0; lane < 4; lane++) begin : g_lane
    if (lane == 0) begin : g_lane0
      assign ioOut[lane] = (ctl.drive == DRV_ONE) ? shiftReg[31] : shiftReg[28];
      assign ioOe[lane]  = (ctl.drive != DRV_OFF);
    end else begin : g_laneN
      assign ioOut[lane] = (ctl.drive == DRV_QUAD) ? shiftReg[28 + lane] : 1'b0;
      assign ioOe[lane]  = (ctl.drive == DRV_QUAD);
    end
  end

  // R13
  out_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    sckIn |-> $stable(ioOut));
  // R10
  rx_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pushRx |-> !rxFull);
endmodule

// File: rtl/qspi_ctrl.sv
module qspi_ctrl
  import qspi_seq_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdStart,
  input  logic [31:0]      cmdWord,
  input  logic [LEN_W-1:0] xferLen,
  input  logic [PRE_W-1:0] clkDiv,
  input  logic             txEmpty,
  input  logic             rxFull,
  input  logic             doneClr,
  output dp_ctl_t          ctl,
  output logic             sck,
  output logic             csN,
  output logic             busy,
  output logic             doneFlag
);
  localparam int RW = LEN_W + 2;
  localparam int DW = PRE_W + 1;

  phase_t           state;
  logic [31:0]      cmdR;
  logic [LEN_W-1:0] lenR;
  logic [RW-1:0]    remain;
  logic [DW-1:0]    divCnt;
  logic             sckR, needByte, doneR;

  function automatic logic [3:0] phaseEn(logic [31:0] w);
    return {w[DMODE_LSB +: 2] != 2'b00, w[DCYC_LSB +: 5] != 5'd0,
            w[AMODE_LSB +: 2] != 2'b00, w[IMODE_LSB +: 2] != 2'b00};
  endfunction

  // First enabled phase at or after index startIdx; PH_GUARD when none remain.
  function automatic phase_t pickFrom(int startIdx, logic [3:0] en);
    phase_t r = PH_GUARD;
    for (int i = 3; i >= 0; i--)
      if (i >= startIdx && en[i]) r = phase_t'(3'(i + 1));
    return r;
  endfunction

  function automatic logic [RW-1:0] phaseLen(phase_t p, logic [31:0] w, logic [LEN_W-1:0] n);
    case (p)
      PH_INSTR: return (w[IMODE_LSB +: 2] == 2'b01) ? RW'(8) : RW'(2);
      PH_ADDR:  return RW'(6);
      PH_DUMMY: return RW'(w[DCYC_LSB +: 5]);
      PH_DATA:  return {({1'b0, n} + 1'b1), 1'b0};
      default:  return '0;
    endcase
  endfunction

  logic [PRE_W-1:0] effDiv;
  logic [DW-1:0]    period, hiLen, loLen;
  assign effDiv = (clkDiv == '0) ? PRE_W'(1) : clkDiv;
  assign period = {1'b0, effDiv} + DW'(1);
  assign hiLen  = period >> 1;
  assign loLen  = period - hiLen;

  wire    active   = (state != PH_IDLE) && (state != PH_GUARD);
  wire    isRead   = (cmdR[FMODE_LSB +: 2] == FMODE_READ);
  wire    single   = (cmdR[IMODE_LSB +: 2] == 2'b01);
  wire    inData   = (state == PH_DATA);
  wire    canRise  = !(inData && (isRead ? rxFull : needByte));
  wire    riseNow  = active && !sckR && (divCnt == loLen - 1'b1) && canRise;
  wire    fallNow  = active && sckR && (divCnt == hiLen - 1'b1);
  wire    lastClk  = (remain == RW'(1));
  wire    accept   = (state == PH_IDLE) && cmdStart;
  phase_t firstPh, nextPh;
  assign firstPh = pickFrom(0, phaseEn(cmdWord));
  assign nextPh  = pickFrom(int'(state), phaseEn(cmdR));

  always_comb begin
    ctl = '0;
    ctl.accept    = accept;
    ctl.loadInstr = accept && (firstPh == PH_INSTR);
    ctl.loadAddr  = (accept && firstPh == PH_ADDR) || (fallNow && lastClk && nextPh == PH_ADDR);
    ctl.loadTx    = inData && !isRead && needByte && !txEmpty;
    ctl.shift1    = fallNow && !lastClk && state == PH_INSTR && single;
    ctl.shift4    = fallNow && !lastClk && ((state == PH_INSTR && !single) || state == PH_ADDR ||
                    (inData && !isRead && !remain[0]));
    ctl.sampleIn  = fallNow && inData && isRead;
    ctl.pushRx    = fallNow && inData && isRead && remain[0];
    case (state)
      PH_INSTR: ctl.drive = single ? DRV_ONE : DRV_QUAD;
      PH_ADDR:  ctl.drive = DRV_QUAD;
      PH_DATA:  ctl.drive = isRead ? DRV_OFF : DRV_QUAD;
      default:  ctl.drive = DRV_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= PH_IDLE; cmdR <= '0; lenR <= '0; remain <= '0;
      divCnt <= '0; sckR <= 1'b0; needByte <= 1'b0; doneR <= 1'b0;
    end else begin
      if (doneClr) doneR <= 1'b0;
      if (ctl.loadTx) needByte <= 1'b0;
      case (state)
        PH_IDLE: if (accept) begin
          cmdR   <= cmdWord;
          lenR   <= xferLen;
          state  <= firstPh;
          divCnt <= '0;
          remain <= phaseLen(firstPh, cmdWord, xferLen);
          needByte <= (firstPh == PH_DATA) && (cmdWord[FMODE_LSB +: 2] != FMODE_READ);
          if (firstPh == PH_GUARD) doneR <= 1'b1;
        end
        PH_GUARD: begin
          if (divCnt == period - 1'b1) begin
            state <= PH_IDLE; divCnt <= '0;
          end else divCnt <= divCnt + 1'b1;
        end
        default: begin
          if (riseNow) begin
            sckR <= 1'b1; divCnt <= '0;
          end else if (fallNow) begin
            sckR <= 1'b0; divCnt <= '0;
            if (lastClk) begin
              state  <= nextPh;
              remain <= phaseLen(nextPh, cmdR, lenR);
              needByte <= (nextPh == PH_DATA) && !isRead;
              if (nextPh == PH_GUARD) doneR <= 1'b1;
            end else begin
              remain <= remain - 1'b1;
              if (inData && !isRead && remain[0]) needByte <= 1'b1;
            end
          end else if (sckR || divCnt != loLen - 1'b1) divCnt <= divCnt + 1'b1;
        end
      endcase
    end
  end

  assign sck      = sckR;
  assign csN      = !active;
  assign busy     = (state != PH_IDLE);
  assign doneFlag = doneR;

  // R2
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rstN) csN |-> !sck);
  // R11
  busy_cs_chk: assert property (@(posedge clk) disable iff (!rstN) !csN |-> busy);
  // R9
  tx_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inData && !isRead && needByte && !sckR) |=> !sck);
  // R10
  rx_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inData && isRead && rxFull && !sckR) |=> !sck);
  // R12
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !doneClr) |=> doneFlag);
endmodule

// File: rtl/qspi_cmd_seq.sv
module qspi_cmd_seq
  import qspi_seq_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int LEN_W      = 16,
  parameter int PRE_W      = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdStart,
  input  logic [31:0]      cmdWord,
  input  logic [23:0]      cmdAddr,
  input  logic [LEN_W-1:0] xferLen,
  input  logic [PRE_W-1:0] clkDiv,
  input  logic [7:0]       txData,
  input  logic             txPush,
  output logic             txFull,
  output logic [7:0]       rxData,
  input  logic             rxPop,
  output logic             rxEmpty,
  input  logic             doneClr,
  output logic             doneFlag,
  output logic             busy,
  output logic             csN,
  output logic             sck,
  output logic [3:0]       ioOut,
  output logic [3:0]       ioOe,
  input  logic [3:0]       ioIn
);
  dp_ctl_t ctl;
  logic    txEmpty, rxFull;

  qspi_ctrl #(.LEN_W(LEN_W), .PRE_W(PRE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdWord(cmdWord),
    .xferLen(xferLen), .clkDiv(clkDiv), .txEmpty(txEmpty), .rxFull(rxFull),
    .doneClr(doneClr), .ctl(ctl), .sck(sck), .csN(csN), .busy(busy),
    .doneFlag(doneFlag)
  );

  qspi_dp #(.FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sckIn(sck),
    .cmdInstr(cmdWord[INSTR_LSB +: 8]), .cmdAddr(cmdAddr),
    .txData(txData), .txPush(txPush), .rxPop(rxPop), .ioIn(ioIn),
    .ioOut(ioOut), .ioOe(ioOe), .txFull(txFull), .txEmpty(txEmpty),
    .rxData(rxData), .rxEmpty(rxEmpty), .rxFull(rxFull)
  );
endmodule

// File: tb/qspi_cmd_seq_bench.sv
module qspi_cmd_seq_bench;
  logic        clk = 0, rstN = 0;
  logic        cmdStart = 0, txPush = 0, rxPop = 0, doneClr = 0;
  logic [31:0] cmdWord = '0;
  logic [23:0] cmdAddr = '0;
  logic [15:0] xferLen = '0;
  logic [7:0]  clkDiv = 8'd1, txData = '0, rxData;
  logic        txFull, rxEmpty, doneFlag, busy, csN, sck;
  logic [3:0]  ioOut, ioOe, ioIn = '0;

  qspi_cmd_seq u_qspi_cmd_seq (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdWord(cmdWord), .cmdAddr(cmdAddr),
    .xferLen(xferLen), .clkDiv(clkDiv), .txData(txData), .txPush(txPush),
    .txFull(txFull), .rxData(rxData), .rxPop(rxPop), .rxEmpty(rxEmpty),
    .doneClr(doneClr), .doneFlag(doneFlag), .busy(busy), .csN(csN), .sck(sck),
    .ioOut(ioOut), .ioOe(ioOe), .ioIn(ioIn)
  );

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0, errors = 0;
  bit finished = 0;

  // Bus monitor and flash model, evaluated away from the active edge.
  logic [3:0] nibLog [64];
  logic [3:0] oeLog  [64];
  int riseT [64];
  int riseCnt = 0, fallCnt = 0, cyc = 0, hiCycles = 0, csHighRun = 0, lastGap = 0;
  int preData = 0, seed = 0;
  logic prevSck = 0, prevCs = 1;

  function automatic logic [3:0] pat(int j);
    return 4'((j * 5 + seed) & 15);
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (!csN && prevCs) begin
      lastGap = csHighRun; riseCnt = 0; fallCnt = 0; hiCycles = 0;
    end
    csHighRun = csN ? csHighRun + 1 : 0;
    if (!csN && sck) hiCycles++;
    if (!csN && sck && !prevSck) begin
      if (riseCnt < 64) begin
        nibLog[riseCnt] = ioOut; oeLog[riseCnt] = ioOe; riseT[riseCnt] = cyc;
      end
      riseCnt++;
    end
    if (!csN && !sck && prevSck) begin
      fallCnt++;
      if (fallCnt >= preData) ioIn = pat(fallCnt - preData);
    end
    prevSck = sck; prevCs = csN;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [31:0] mkWord(logic [7:0] ins, logic [1:0] im, logic [1:0] am,
                                         logic [4:0] dc, logic [1:0] dm, logic [1:0] fm);
    return {4'h0, fm, dm, 1'b0, dc, 4'h0, (am != 0) ? 2'b10 : 2'b00, am, im, ins};
  endfunction

  task automatic issue(logic [31:0] w, logic [23:0] a, logic [15:0] len, logic [7:0] dv);
    @(negedge clk);
    cmdWord = w; cmdAddr = a; xferLen = len; clkDiv = dv; cmdStart = 1;
    @(negedge clk);
    cmdStart = 0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic clearDone();
    @(negedge clk); doneClr = 1; @(negedge clk); doneClr = 0;
  endtask

  task automatic pushTx(logic [7:0] b);
    @(negedge clk); txData = b; txPush = 1; @(negedge clk); txPush = 0;
  endtask

  task automatic popRx(string req, logic [7:0] exp);
    while (rxEmpty) @(negedge clk);
    chk(req, rxData, exp);
    rxPop = 1; @(negedge clk); rxPop = 0;
  endtask

  task automatic testReset();
    chk("R1 csN", csN, 1); chk("R1 sck", sck, 0); chk("R1 busy", busy, 0);
    chk("R1 done", doneFlag, 0); chk("R1 oe", ioOe, 0);
    chk("R1 rxEmpty", rxEmpty, 1); chk("R1 txFull", txFull, 0);
  endtask

  task automatic testQuadRead();
    seed = 3; preData = 12;
    issue(mkWord(8'hEB, 2'b11, 2'b11, 5'd4, 2'b11, 2'b01), 24'h123456, 16'd3, 8'd1);
    waitIdle();
    chk("R6 read clocks", riseCnt, 20);
    chk("R3 instr hi", nibLog[0], 4'hE); chk("R3 instr lo", nibLog[1], 4'hB);
    chk("R3 instr oe", oeLog[0], 4'hF);
    for (int k = 0; k < 6; k++) chk("R4 addr nibble", nibLog[2 + k], 4'(k + 1));
    chk("R4 addr oe", oeLog[7], 4'hF);
    for (int k = 8; k < 12; k++) chk("R5 dummy oe", oeLog[k], 0);
    chk("R7 data oe", oeLog[15], 0);
    for (int b = 0; b < 4; b++) popRx("R7 read byte", {pat(2 * b), pat(2 * b + 1)});
    chk("R7 rx drained", rxEmpty, 1);
    chk("R12 done set", doneFlag, 1);
    repeat (5) @(negedge clk);
    chk("R12 done held", doneFlag, 1);
    clearDone();
    chk("R12 done cleared", doneFlag, 0);
  endtask

  task automatic testSingleInstr();
    preData = 99;
    issue(mkWord(8'h96, 2'b01, 2'b00, 5'd0, 2'b00, 2'b00), 24'h0, 16'd0, 8'd1);
    waitIdle();
    chk("R3 one-lane clocks", riseCnt, 8);
    for (int k = 0; k < 8; k++) chk("R3 one-lane bit", nibLog[k][0], (8'h96 >> (7 - k)) & 1);
    chk("R3 one-lane oe", oeLog[3], 4'h1);
    clearDone();
    issue(mkWord(8'h20, 2'b11, 2'b11, 5'd0, 2'b00, 2'b00), 24'hFEDCBA, 16'd5, 8'd1);
    waitIdle();
    chk("R8 no data phase", riseCnt, 8);
    chk("R8 last addr nibble", nibLog[7], 4'hA);
    clearDone();
  endtask

  task automatic testQuadWrite();
    preData = 99;
    pushTx(8'hA5); pushTx(8'h3C); pushTx(8'h7E);
    issue(mkWord(8'h32, 2'b11, 2'b11, 5'd0, 2'b11, 2'b00), 24'hABCDEF, 16'd2, 8'd1);
    waitIdle();
    chk("R8 write clocks", riseCnt, 14);
    chk("R8 wdata 0", {nibLog[8], nibLog[9]}, 8'hA5);
    chk("R8 wdata 1", {nibLog[10], nibLog[11]}, 8'h3C);
    chk("R8 wdata 2", {nibLog[12], nibLog[13]}, 8'h7E);
    chk("R8 wdata oe", oeLog[12], 4'hF);
    chk("R4 addr first", nibLog[2], 4'hA);
    clearDone();
  endtask

  task automatic testTxStall();
    preData = 99;
    issue(mkWord(8'h38, 2'b11, 2'b00, 5'd0, 2'b11, 2'b00), 24'h0, 16'd0, 8'd1);
    repeat (40) @(negedge clk);
    chk("R9 stalled clocks", riseCnt, 2);
    chk("R9 stalled busy", busy, 1);
    chk("R9 stalled sck", sck, 0);
    pushTx(8'h5A);
    waitIdle();
    chk("R9 resumed clocks", riseCnt, 4);
    chk("R9 resumed byte", {nibLog[2], nibLog[3]}, 8'h5A);
    clearDone();
  endtask

  task automatic testRxStall();
    seed = 9; preData = 4;
    issue(mkWord(8'h6B, 2'b11, 2'b00, 5'd2, 2'b11, 2'b01), 24'h0, 16'd5, 8'd1);
    repeat (60) @(negedge clk);
    chk("R10 stalled clocks", riseCnt, 12);
    chk("R10 stalled busy", busy, 1);
    for (int b = 0; b < 6; b++) popRx("R10 byte after stall", {pat(2 * b), pat(2 * b + 1)});
    waitIdle();
    chk("R10 total clocks", riseCnt, 16);
    clearDone();
  endtask

  task automatic testLenZero();
    seed = 1; preData = 2;
    issue(mkWord(8'h05, 2'b11, 2'b00, 5'd0, 2'b11, 2'b01), 24'h0, 16'd0, 8'd1);
    waitIdle();
    chk("R6 one byte clocks", riseCnt, 4);
    popRx("R6 single byte", {pat(0), pat(1)});
    chk("R6 nothing extra", rxEmpty, 1);
    clearDone();
  endtask

  task automatic testDivider();
    preData = 99;
    issue(mkWord(8'h01, 2'b01, 2'b00, 5'd0, 2'b00, 2'b00), 24'h0, 16'd0, 8'd3);
    waitIdle();
    chk("R2 period div3", riseT[1] - riseT[0], 4);
    chk("R2 high time div3", hiCycles, 16);
    issue(mkWord(8'h01, 2'b01, 2'b00, 5'd0, 2'b00, 2'b00), 24'h0, 16'd0, 8'd4);
    waitIdle();
    chk("R2 period div4", riseT[5] - riseT[4], 5);
    chk("R2 high time div4", hiCycles, 16);
    issue(mkWord(8'h01, 2'b01, 2'b00, 5'd0, 2'b00, 2'b00), 24'h0, 16'd0, 8'd0);
    waitIdle();
    chk("R2 div0 as div1", riseT[2] - riseT[1], 2);
    clearDone();
  endtask

  task automatic testBusyIgnore();
    preData = 99;
    issue(mkWord(8'hC7, 2'b11, 2'b00, 5'd0, 2'b00, 2'b00), 24'h0, 16'd0, 8'd3);
    issue(mkWord(8'h81, 2'b01, 2'b11, 5'd3, 2'b00, 2'b00), 24'h0, 16'd0, 8'd3);
    waitIdle();
    chk("R11 first only clocks", riseCnt, 2);
    chk("R11 first instr", {nibLog[0], nibLog[1]}, 8'hC7);
    repeat (10) @(negedge clk);
    chk("R11 no second start", csN, 1);
    issue(mkWord(8'h66, 2'b11, 2'b00, 5'd0, 2'b00, 2'b00), 24'h0, 16'd0, 8'd3);
    waitIdle();
    issue(mkWord(8'h99, 2'b11, 2'b00, 5'd0, 2'b00, 2'b00), 24'h0, 16'd0, 8'd3);
    waitIdle();
    chk("R11 guard gap", lastGap >= 4, 1);
    chk("R11 back-to-back instr", {nibLog[0], nibLog[1]}, 8'h99);
    clearDone();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testQuadRead();
    testSingleInstr();
    testQuadWrite();
    testTxStall();
    testRxStall();
    testLenZero();
    testDivider();
    testBusyIgnore();
    finishRun();
  end
endmodule